// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output whose duty values never go straight to the comparator. Software writes each new duty value into a four-deep sample queue. The period logic takes one entry from the queue at every period boundary and loads it into the active compare register. A duty change can therefore never cut a period short or stretch it.

When the queue runs dry, the output keeps repeating the last value it loaded. A small register port sets the prescale divisor, the period length and the enable. It also accepts samples and returns the live compare value and a status word. The status word gives the queue fill level and a sticky overflow flag.

The input clock first passes through a programmable divider. The period counter advances once per divided tick. The output is high while the counter is below the active compare value.

Register map (two-bit address): 0 = control (bit 0 enable, bits 15:4 prescale minus one), 1 = period, 2 = sample, 3 = status (bits 2:0 fill level, bit 3 overflow; a write with bit 3 set clears the overflow).

Top module: `dutyq_pwm`

## Requirements
- R1: The sample queue holds 4 entries. Status bits 2:0 give the number of occupied entries, and the value 0 means empty.
- R2: A sample written during a period does not change that period's pulse. It is first used at a later period boundary.
- R3: Entries leave the queue in write order, one per period boundary. When the queue is empty, every following period repeats the last loaded value.
- R4: A sample write to a full queue is discarded and sets status bit 3. That bit stays set until a status write with bit 3 high clears it.
- R5: While enabled, reading address 2 returns the compare value in use, not the last value written. While disabled, the read returns 0.
- R6: One period lasts (period register + 1) counter ticks. A period register of 0xFFFF behaves exactly like 0xFFFE, giving 65535 ticks.
- R7: A counter tick occurs every (prescale + 1) input clocks, so the high time is sample × (prescale + 1) clocks.
- R8: The output is high while the counter is below the active compare value. A compare value of 0 keeps the output low for the whole period.
- R9: After reset, or after the enable is cleared, the output is low and the counter restarts. Clearing the enable also empties the queue and zeroes the active compare value.
- R10: The first tick after enabling starts a new period and pops the queue head if one is present. If the queue is empty, the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_o | output | 1 | Modulated output |

## Verification
The hardest situation to reach is a sample write that lands while a pulse is already high. Only in that case can a design that applies duties immediately be told apart from one that waits for the boundary. The stimulus watches the output, waits for a rising edge and writes a new value within the next two clocks. A scoreboard has already been loaded with the expected widths: the old width for the current pulse and the new width after it. A second hard case is the 0xFFFF period. It is reached by disabling, queueing one short sample and re-enabling, so that two rising edges exactly one long period apart appear at the output.

// File: rtl/dutyq_pkg.sv
package dutyq_pkg;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_PERIOD = 2'd1,
    RA_SAMPLE = 2'd2,
    RA_STATUS = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PRE_LSB = 4;

endpackage

// File: rtl/dutyq_rst_sync.sv
module dutyq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dutyq_prescaler.sv
module dutyq_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);

  logic [PRE_W-1:0] div_q, div_d;

  assign tick = en && (div_q >= pre);

  always_comb begin
    div_d = div_q;
    if (!en)       div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre != '0) |=> (!tick || pre == '0));

endmodule

// File: rtl/dutyq_fifo.sv
module dutyq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [DW-1:0]    head,
  output logic             valid,
  output logic             full,
  output logic [CNT_W-1:0] level
);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, take;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign valid  = (cnt_q != '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign level  = cnt_q;
  assign head   = mem_q[rd_q];
  assign accept = push && !full && !flush;
  assign take   = pop && valid && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (accept) wr_d = ptr_inc(wr_q);
      if (take)   rd_d = ptr_inc(rd_q);
      case ({accept, take})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && wr_q == PTR_W'(i)) mem_q[i] <= push_data;
    end
  end

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == CNT_W'(DEPTH)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/dutyq_period.sv
module dutyq_period #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [DW-1:0] eff_period,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_head,
  output logic          pop,
  output logic [DW-1:0] active,
  output logic          pwm
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] cmp_q, cmp_d;
  logic          fresh_q, fresh_d;
  logic          boundary;

  assign boundary = tick && (fresh_q || cnt_q >= eff_period);
  assign pop      = boundary && fifo_valid;
  assign active   = cmp_q;
  assign pwm      = en && !fresh_q && (cnt_q < cmp_q);

  always_comb begin
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    fresh_d = fresh_q;
    if (!en) begin
      cnt_d   = '0;
      cmp_d   = '0;
      fresh_d = 1'b1;
    end else if (tick) begin
      fresh_d = 1'b0;
      if (boundary) cnt_d = '0;
      else          cnt_d = cnt_q + DW'(1);
      if (pop)      cmp_d = fifo_head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
      fresh_q <= fresh_d;
    end
  end

  // R2
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pop) |=> $stable(cmp_q));

  // R8
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q == '0) |-> !pwm);

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm);

  // R3
  pop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> tick);

endmodule

// File: rtl/dutyq_pwm.sv
module dutyq_pwm
  import dutyq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int PRE_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pwm_o
);

  localparam int            CNT_W      = $clog2(DEPTH + 1);
  localparam int            OVF_BIT    = CNT_W;
  localparam logic [DW-1:0] PERIOD_TOP = {DW{1'b1}};

  logic             srst_n;
  logic             en_q, en_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DW-1:0]    period_q, period_d;
  logic             ovf_q, ovf_d;
  logic             wr_ctrl, wr_period, wr_sample, wr_status;
  logic             flush, tick, pop, fifo_valid, fifo_full;
  logic [DW-1:0]    fifo_head, active, eff_period;
  logic [CNT_W-1:0] level;

  dutyq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_period = reg_wr && (reg_addr == RA_PERIOD);
  assign wr_sample = reg_wr && (reg_addr == RA_SAMPLE);
  assign wr_status = reg_wr && (reg_addr == RA_STATUS);
  assign flush     = en_q && wr_ctrl && !reg_wdata[CTRL_EN_BIT];
  assign eff_period = (period_q == PERIOD_TOP) ? (PERIOD_TOP - DW'(1)) : period_q;

  always_comb begin
    en_d     = en_q;
    pre_d    = pre_q;
    period_d = period_q;
    ovf_d    = ovf_q;
    if (wr_ctrl) begin
      en_d  = reg_wdata[CTRL_EN_BIT];
      pre_d = reg_wdata[CTRL_PRE_LSB +: PRE_W];
    end
    if (wr_period) period_d = reg_wdata;
    if (wr_sample && fifo_full)                 ovf_d = 1'b1;
    else if (wr_status && reg_wdata[OVF_BIT])   ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q     <= 1'b0;
      pre_q    <= '0;
      period_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      en_q     <= en_d;
      pre_q    <= pre_d;
      period_q <= period_d;
      ovf_q    <= ovf_d;
    end
  end

  dutyq_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (en_q),
    .pre   (pre_q),
    .tick  (tick)
  );

  dutyq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (wr_sample),
    .push_data (reg_wdata),
    .pop       (pop),
    .flush     (flush),
    .head      (fifo_head),
    .valid     (fifo_valid),
    .full      (fifo_full),
    .level     (level)
  );

  dutyq_period #(.DW(DW)) u_per (
    .clk        (clk),
    .rst_n      (srst_n),
    .en         (en_q),
    .tick       (tick),
    .eff_period (eff_period),
    .fifo_valid (fifo_valid),
    .fifo_head  (fifo_head),
    .pop        (pop),
    .active     (active),
    .pwm        (pwm_o)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[CTRL_EN_BIT]              = en_q;
        rd_data[CTRL_PRE_LSB +: PRE_W]    = pre_q;
      end
      RA_PERIOD: rd_data = period_q;
      RA_SAMPLE: rd_data = en_q ? active : '0;
      default: begin
        rd_data[CNT_W-1:0] = level;
        rd_data[OVF_BIT]   = ovf_q;
      end
    endcase
  end

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ovf_q && !(wr_status && reg_wdata[OVF_BIT])) |=> ovf_q);

  // R5
  rd_off_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!en_q && rd_addr == RA_SAMPLE) |-> (rd_data == '0));

endmodule

// File: tb/dutyq_pwm_tb.sv
module dutyq_pwm_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        pwm_o;

  always #10 clk = ~clk;

  dutyq_pwm u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pwm_o     (pwm_o)
  );

  typedef struct {
    int    w;
    string req;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   rise_cnt = 0;
  int   rise_gap = 0;
  int   last_rise = 0;
  int   run_len = 0;
  bit   had_rise = 1'b0;
  bit   prev_pwm = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_pulse(input int w, input string req);
    exp_t e;
    e.w = w;
    e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: measures pulse widths and rise-to-rise gaps, compares against the queue
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pwm = 1'b0;
      had_rise = 1'b0;
    end else begin
      if (pwm_o && !prev_pwm) begin
        rise_cnt++;
        if (had_rise) rise_gap = cyc - last_rise;
        last_rise = cyc;
        had_rise = 1'b1;
        run_len = 1;
      end else if (pwm_o) begin
        run_len++;
      end else if (prev_pwm) begin
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check(run_len == e.w, e.req, run_len, e.w);
        end
      end
      prev_pwm = pwm_o;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int v;
    int r0;
    bit hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    rd(2'd3, v); check(v == 0, "R9 status", v, 0);
    rd(2'd2, v); check(v == 0, "R9 sample", v, 0);
    rd(2'd0, v); check(v == 0, "R9 ctrl", v, 0);
    check(pwm_o == 1'b0, "R9 pwm", int'(pwm_o), 0);

    // R1 R3 R10: prefill three samples, period 9 -> 10 clocks
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd3);
    wr(2'd2, 16'd5);
    wr(2'd2, 16'd7);
    rd(2'd3, v); check(v == 3, "R1 fill three", v, 3);
    expect_pulse(3, "R10 first pop");
    expect_pulse(5, "R3 order");
    expect_pulse(7, "R3 order");
    expect_pulse(7, "R3 repeat last");
    wr(2'd0, 16'h0001);
    drain();
    rd(2'd3, v); check(v == 0, "R1 empty code", v, 0);
    rd(2'd2, v); check(v == 7, "R5 live value", v, 7);
    check(rise_gap == 10, "R6 period 9", rise_gap, 10);

    // R2: write during a high pulse
    r0 = rise_cnt;
    while (rise_cnt == r0) @(negedge clk);
    expect_pulse(7, "R2 current pulse kept");
    expect_pulse(2, "R2 next pulse");
    expect_pulse(2, "R3 repeat");
    wr(2'd2, 16'd2);
    @(negedge clk);
    rd(2'd2, v); check(v == 7, "R5 not last written", v, 7);
    drain();

    // R8: compare of zero
    wr(2'd2, 16'd0);
    hi = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (pwm_o) hi = 1'b1;
    end
    check(hi == 1'b0, "R8 zero stays low", int'(hi), 0);
    rd(2'd2, v); check(v == 0, "R8 active zero", v, 0);

    // R4 R9: disable, overfill, clear
    wr(2'd0, 16'h0000);
    check(pwm_o == 1'b0, "R9 off low", int'(pwm_o), 0);
    wr(2'd2, 16'd1);
    wr(2'd2, 16'd2);
    wr(2'd2, 16'd3);
    wr(2'd2, 16'd4);
    wr(2'd2, 16'd6);
    rd(2'd3, v); check(v == 12, "R4 full plus overflow", v, 12);
    rd(2'd2, v); check(v == 0, "R5 disabled read", v, 0);
    wr(2'd3, 16'h0008);
    rd(2'd3, v); check(v == 4, "R4 overflow cleared", v, 4);

    // R7: prescale 3, sample widths x3, dropped value absent (R4)
    expect_pulse(3, "R7 width 1x3");
    expect_pulse(6, "R7 width 2x3");
    expect_pulse(9, "R7 width 3x3");
    expect_pulse(12, "R4 dropped write absent");
    expect_pulse(12, "R3 repeat prescaled");
    wr(2'd0, 16'h0021);
    drain();
    check(rise_gap == 30, "R7 period scaled", rise_gap, 30);

    // R9: disable flushes queued samples
    wr(2'd2, 16'd5);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0000);
    rd(2'd3, v); check(v == 0, "R9 flushed", v, 0);
    wr(2'd0, 16'h0001);
    hi = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_o) hi = 1'b1;
    end
    check(hi == 1'b0, "R9 no stale duty", int'(hi), 0);

    // R6: 0xFFFF acts as 0xFFFE
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'd1);
    r0 = rise_cnt;
    wr(2'd0, 16'h0001);
    while (rise_cnt < r0 + 2) @(negedge clk);
    check(rise_gap == 65535, "R6 top period", rise_gap, 65535);

    finish_run();
  end

endmodule